// File: doc/BRIEF.md
# Watch Timer with Tone Output

The block counts the system clock in one free-running binary divider. Two results come from fixed power-of-two taps of that divider. The first is a periodic interval request, with a long and a short period to choose from. The second is a square-wave tone for a buzzer pin, at one of four frequencies. With the default parameters and a 4.194304 MHz clock, the long interval is 0.5 s and the short interval is about 3.91 ms. The tone frequencies are then 16, 8, 4 and 2 kHz.

Software controls the block through an 8-bit mode register with a single write port. Each elapsed interval produces a one-cycle request pulse. It also sets a sticky request flag, which behaves as a flag-only interrupt: it is set, but nothing is vectored. The flag stays set until software writes a clear strobe.

A new tone selection takes effect only at an edge of the newly selected tap, so the pin never shows a shortened high or low phase. Clearing the run bit holds the divider at zero and drives the pin low.

Top module: `watch_tone_timer`

## Requirements
- R1: After reset the mode register is zero, and req_pulse, req_flag and buz_pin are all low.
- R2: A write (wr_en high) loads wr_data into the mode register at the clock edge. The fields are: bit 0 is the run bit, bit 1 is the short-interval select (1 = short), bits 3:2 are the tone code, and bit 4 is the tone enable. Bits 7:5 have no function.
- R3: While running, req_pulse is high for exactly one cycle every 2^SHORT_TAP cycles when bit 1 is 1, and every 2^LONG_TAP cycles when bit 1 is 0. The first pulse comes 2^tap cycles after the write edge that set the run bit.
- R4: Each req_pulse sets req_flag. The flag stays set until a cycle with req_clr high, and the flag is low in the cycle after that strobe. A strobe in the same cycle as a new interval event leaves the flag set.
- R5: While running with the tone enabled and a steady tone code c, buz_pin equals bit (BUZ_BASE-1+c) of the number of cycles since the enabling write edge. The pin is therefore a square wave with a period of 2^(BUZ_BASE+c) cycles.
- R6: With the tone enable bit at 0, buz_pin stays low.
- R7: With the run bit at 0, the divider is held at zero, no req_pulse occurs, and buz_pin is low from the second cycle after the write. Setting the run bit again restarts the interval count from zero.
- R8: A change of tone code takes effect at the next edge of the newly selected tap. The pin changes only when the divider's low BUZ_BASE-1 bits are zero, and no high or low phase is shorter than the half period of the faster of the two tones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| req_clr | input | 1 | Clear strobe for the request flag |
| req_pulse | output | 1 | One-cycle interval request |
| req_flag | output | 1 | Sticky interval request flag |
| buz_pin | output | 1 | Tone output |

## Verification
The assertions check several properties on every cycle:
- A request pulse lasts one cycle and always comes with the flag set.
- The flag falls only after a clear strobe.
- A stopped timer makes no pulse and leaves the pin low.
- Every tone-pin transition, once the enables are steady, lands where the divider's low bits are zero.

The bench's scenarios show what no single-cycle property can:
- the exact interval spacing for both periods, and the restart from zero;
- the tone waveform for each code;
- the priority of a new event over a clear in the same cycle;
- the absence of short phases when the tone code changes mid-run.

// File: rtl/wtt_pkg.sv
package wtt_pkg;
   localparam int MODE_W = 8;

   typedef struct packed {
      logic [2:0] spare;
      logic       tone_en;
      logic [1:0] tone_sel;
      logic       fast;
      logic       run;
   } wtt_mode_t;
endpackage

// File: rtl/wtt_divider.sv
module wtt_divider #(
   parameter int CNT_W     = 21,
   parameter int SHORT_TAP = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fast,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nx,
   output logic             tick
);
   localparam logic [CNT_W-1:0] LONG_MASK  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] SHORT_MASK = {CNT_W{1'b1}} >> (CNT_W - SHORT_TAP);

   generate
      if (SHORT_TAP < 1 || SHORT_TAP >= CNT_W) begin : g_bad_tap
         $error("wtt_divider: SHORT_TAP must lie in 1..CNT_W-1");
      end
   endgenerate

   logic [CNT_W-1:0] sel_mask;

   assign cnt_nx   = cnt + 1'b1;
   assign sel_mask = fast ? SHORT_MASK : LONG_MASK;
   assign tick     = run && ((cnt & sel_mask) == sel_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt_nx;
      else          cnt <= '0;
   end

   a_r7_held_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/wtt_tone.sv
module wtt_tone #(
   parameter int CNT_W     = 21,
   parameter int BUZ_BASE  = 8,
   parameter int NUM_TONES = 4,
   localparam int SEL_W    = $clog2(NUM_TONES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tone_en,
   input  logic [SEL_W-1:0] tone_sel,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_nx,
   output logic             buz_pin
);
   localparam int LOW_B = BUZ_BASE - 1;

   generate
      if (BUZ_BASE < 2 || BUZ_BASE + NUM_TONES - 2 > CNT_W - 1) begin : g_bad_base
         $error("wtt_tone: tone taps fall outside the divider");
      end
      if ((1 << SEL_W) != NUM_TONES) begin : g_bad_count
         $error("wtt_tone: NUM_TONES must be a power of two");
      end
   endgenerate

   logic [NUM_TONES-1:0] tone_bit;
   logic [NUM_TONES-1:0] tone_edge;

   for (genvar g = 0; g < NUM_TONES; g++) begin : g_tap
      assign tone_bit[g]  = cnt_nx[BUZ_BASE-1+g];
      assign tone_edge[g] = &cnt[BUZ_BASE-2+g:0];
   end

   logic [SEL_W-1:0] act_sel;
   logic [SEL_W-1:0] nxt_sel;

   always_comb begin
      nxt_sel = act_sel;
      if (!run)
         nxt_sel = tone_sel;
      else if (tone_sel != act_sel && tone_edge[tone_sel])
         nxt_sel = tone_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel <= '0;
         buz_pin <= 1'b0;
      end else begin
         act_sel <= nxt_sel;
         buz_pin <= run & tone_en & tone_bit[nxt_sel];
      end
   end

   a_r8_pin_edges_on_tap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && tone_en && $past(tone_en, 2) && buz_pin != $past(buz_pin))
      |-> (cnt[LOW_B-1:0] == '0));
endmodule

// File: rtl/wtt_req.sv
module wtt_req (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic req_pulse,
   output logic req_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_pulse <= 1'b0;
         req_flag  <= 1'b0;
      end else begin
         req_pulse <= tick;
         req_flag  <= tick | (req_flag & ~clr);
      end
   end

   a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_pulse |=> !req_pulse);
   a_r4_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      req_pulse |-> req_flag);
   a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_flag) |-> $past(clr));
endmodule

// File: rtl/watch_tone_timer.sv
module watch_tone_timer
   import wtt_pkg::*;
#(
   parameter int LONG_TAP  = 21,
   parameter int SHORT_TAP = 14,
   parameter int BUZ_BASE  = 8,
   parameter int NUM_TONES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   input  logic              req_clr,
   output logic              req_pulse,
   output logic              req_flag,
   output logic              buz_pin
);
   localparam int CNT_W = LONG_TAP;
   localparam int SEL_W = $clog2(NUM_TONES);

   generate
      if (SHORT_TAP >= LONG_TAP) begin : g_bad_order
         $error("watch_tone_timer: SHORT_TAP must be below LONG_TAP");
      end
      if (SEL_W != 2) begin : g_bad_field
         $error("watch_tone_timer: mode register holds a 2-bit tone code");
      end
   endgenerate

   wtt_mode_t        mode_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nx;
   logic             tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= '0;
      else if (wr_en) mode_q <= wtt_mode_t'(wr_data);
   end

   wtt_divider #(.CNT_W(CNT_W), .SHORT_TAP(SHORT_TAP)) u_div (
      .clk(clk), .rst_n(rst_n), .run(mode_q.run), .fast(mode_q.fast),
      .cnt(cnt), .cnt_nx(cnt_nx), .tick(tick));

   wtt_tone #(.CNT_W(CNT_W), .BUZ_BASE(BUZ_BASE), .NUM_TONES(NUM_TONES)) u_tone (
      .clk(clk), .rst_n(rst_n), .run(mode_q.run), .tone_en(mode_q.tone_en),
      .tone_sel(mode_q.tone_sel), .cnt(cnt), .cnt_nx(cnt_nx), .buz_pin(buz_pin));

   wtt_req u_req (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(req_clr),
      .req_pulse(req_pulse), .req_flag(req_flag));

   a_r7_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_q.run) |-> (!req_pulse && !buz_pin));
   a_r6_tone_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_q.tone_en) |-> !buz_pin);
endmodule

// File: tb/watch_tone_timer_bench.sv
module watch_tone_timer_bench;
   localparam int LT = 9, ST = 5, BB = 2, NT = 4;

   logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, req_clr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       req_pulse, req_flag, buz_pin;

   watch_tone_timer #(.LONG_TAP(LT), .SHORT_TAP(ST), .BUZ_BASE(BB), .NUM_TONES(NT)) u_watch_tone_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .req_clr(req_clr),
      .req_pulse(req_pulse), .req_flag(req_flag), .buz_pin(buz_pin));

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, errors = 0;
   int exp_q[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
      end
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic logic [7:0] md(input bit run, input bit fast, input int tone, input bit ten);
      return {3'b000, ten, 2'(tone), fast, run};
   endfunction

   task automatic write_mode(input logic [7:0] v, output int base);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      base = cyc;
   endtask

   task automatic wait_until(input int c);
      do @(negedge clk); while (cyc < c);
   endtask

   // scoreboard monitor: expected interval pulses, R3
   always @(negedge clk) begin
      if (rst_n) begin
         while (exp_q.size() > 0 && exp_q[0] < cyc) begin
            check(1'b0, "R3 missed pulse", cyc, exp_q[0]);
            void'(exp_q.pop_front());
         end
         if (req_pulse) begin
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
               check(1'b1, "R3 pulse", cyc, cyc);
               void'(exp_q.pop_front());
            end else begin
               check(1'b0, "R3 unexpected pulse", cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", cyc, 0);
      report();
   end

   initial begin
      int b, w, d, e, mism, minrun, run;
      logic prev;
      repeat (4) @(negedge clk);
      check({req_pulse, req_flag, buz_pin} == 3'b000, "R1 outputs in reset", {req_pulse, req_flag, buz_pin}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check({req_pulse, req_flag, buz_pin} == 3'b000, "R1 idle after reset", {req_pulse, req_flag, buz_pin}, 0);

      // short interval, tone code 0 (bit 1 of elapsed cycles)
      write_mode(md(1, 1, 0, 1), b);
      for (int k = 1; k <= 15; k++) exp_q.push_back(b + 32 * k);
      mism = 0;
      for (int k = 0; k < 220; k++) begin
         wait_until(b + k);
         if (buz_pin != ((k >> 1) & 1)) mism++;
      end
      check(mism == 0, "R5 tone code 0 waveform", mism, 0);
      check(req_flag == 1'b1, "R4 flag set by pulse", req_flag, 1);

      // clear in the same cycle as a new event
      wait_until(b + 223);
      req_clr = 1'b1;
      wait_until(b + 224);
      req_clr = 1'b0;
      check(req_flag == 1'b1, "R4 event wins over clear", req_flag, 1);
      wait_until(b + 230);
      req_clr = 1'b1;
      wait_until(b + 231);
      req_clr = 1'b0;
      check(req_flag == 1'b0, "R4 strobe clears flag", req_flag, 0);
      wait_until(b + 240);
      check(req_flag == 1'b0, "R4 flag stays clear", req_flag, 0);
      wait_until(b + 257);
      check(req_flag == 1'b1, "R4 flag set again", req_flag, 1);

      // switch to tone code 3, then to code 1 at an odd cycle
      wait_until(b + 261);
      write_mode(md(1, 1, 3, 1), w);
      mism = 0;
      for (int k = 300; k < 390; k++) begin
         wait_until(b + k);
         if (buz_pin != ((k >> 4) & 1)) mism++;
      end
      check(mism == 0, "R5 tone code 3 waveform", mism, 0);
      minrun = 1000; run = -1; prev = buz_pin;
      for (int k = 390; k < 400; k++) begin
         wait_until(b + k);
         if (buz_pin != prev) begin
            if (run >= 0 && run < minrun) minrun = run;
            run = 1; prev = buz_pin;
         end else if (run >= 0) run++;
      end
      write_mode(md(1, 1, 1, 1), w);
      mism = 0;
      for (int k = w - b; k < 480; k++) begin
         wait_until(b + k);
         if (buz_pin != prev) begin
            if (run >= 0 && run < minrun) minrun = run;
            run = 1; prev = buz_pin;
         end else if (run >= 0) run++;
         if (k >= 420 && buz_pin != ((k >> 2) & 1)) mism++;
      end
      check(minrun >= 4, "R8 no short phase on code change", minrun, 4);
      check(mism == 0, "R8 new code in force after tap edge", mism, 0);

      // stop
      wait_until(b + 489);
      write_mode(md(0, 1, 1, 1), d);
      exp_q.delete();
      mism = 0;
      for (int k = 1; k < 600; k++) begin
         wait_until(d + k);
         if (buz_pin != 1'b0) mism++;
      end
      check(mism == 0, "R7 pin low while stopped", mism, 0);

      // restart with long interval, tone disabled
      write_mode(md(1, 0, 2, 0), e);
      for (int k = 1; k <= 3; k++) exp_q.push_back(e + 512 * k);
      mism = 0;
      for (int k = 0; k < 1545; k++) begin
         wait_until(e + k);
         if (buz_pin != 1'b0) mism++;
         if (k == 512) check(req_pulse == 1'b1, "R7 restart from zero, R2 run field", req_pulse, 1);
      end
      check(mism == 0, "R6 tone disabled keeps pin low", mism, 0);
      check(exp_q.size() == 0, "R3 all long pulses seen", exp_q.size(), 0);
      report();
   end
endmodule